// File: doc/BRIEF.md
# Hybrid Translation Lookaside Lookup

This block finds the translation entry that covers a virtual address. Its entries sit in two regions. The first region is set-indexed. It has a number of ways, and every way holds one entry per set. All of its entries are compared at one page size, which the caller supplies with each lookup. The second region is small and fully associative. Each of its slots stores its own page size and is compared at that size. Each entry covers a pair of adjacent pages: an even page and an odd page.

A lookup takes a 48-bit virtual address, the current address-space identifier and the global page size (as log2 of the page size in bytes). One cycle later the block returns whether an entry matched and the flat index of that entry. A separate write port loads one entry per cycle. An entry consists of:
- its tag: virtual address bits [47:13];
- a page size, used only by the fully-associative slots;
- an address-space identifier;
- a global flag;
- an exist flag.

Checking access rights and choosing which entry to replace are done outside this block.

Top module: `tlb_lookup`

## Requirements
- R1: After synchronous reset, no entry exists, and `rsp_valid` and `rsp_hit` are 0.
- R2: `rsp_valid` is `lk_valid` delayed by one clock. While `rsp_valid` is 0, `rsp_hit` is 0.
- R3: For a set-indexed lookup, the set is the low 8 bits of `lk_va >> (lk_gps+1)`. A hit in way w of set s reports `rsp_idx = w*256 + s`.
- R4: An entry's stored tag (VA[47:13]) matches when VA bits [47:ps+1] are equal. Here ps is the page size used for the compare, and it must be at least 12. Address bits below ps+1 do not affect the match.
- R5: An entry whose exist flag is 0 never matches.
- R6: A non-global entry matches only when its stored identifier equals `lk_asid`. An entry with the global flag set matches under any identifier.
- R7: Fully-associative slot k reports `rsp_idx = 2048 + k`. It is compared at its own stored page size, whatever the value of `lk_gps`.
- R8: When both regions match, the set-indexed result is reported.
- R9: When several entries match within one region, the lowest index in that region is reported.
- R10: A write takes effect from the next cycle. A lookup presented in the same cycle as a write to the entry it would use sees the entry's old contents.
- R11: A lookup that matches nothing reports `rsp_hit = 0` and `rsp_idx = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Virtual address to translate |
| lk_asid | input | 10 | Current address-space identifier |
| lk_gps | input | 6 | Page size (log2 bytes) for the set-indexed region |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 12 | Flat index of the entry to write |
| wr_vppn | input | 35 | Tag: virtual address bits [47:13] |
| wr_ps | input | 6 | Page size of the entry (fully-associative slots only) |
| wr_asid | input | 10 | Identifier stored in the entry |
| wr_global | input | 1 | Global flag stored in the entry |
| wr_exist | input | 1 | Exist flag stored in the entry |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is present |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | 12 | Flat index of the matching entry, 0 on a miss |

## Verification
A write to an entry and a lookup that would select that entry can occur in the same cycle. The bench causes this by driving both ports on the same clock edge. The first case loads a matching entry into an empty set, and the result is judged a miss. The second case clears the exist flag of a live entry, and the result is judged a hit on the old contents. In both cases a lookup on the next cycle must show the new contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 48;
    localparam int TAG_LSB  = 13;
    localparam int VPPN_W   = VA_W - TAG_LSB;
    localparam int ASID_W   = 10;
    localparam int PS_W     = 6;
    localparam int PS_FLOOR = TAG_LSB - 1;

    // Tag part of an entry: page-pair number, identifier, global flag.
    typedef struct packed {
        logic [VPPN_W-1:0] vppn;
        logic [ASID_W-1:0] asid;
        logic              glob;
    } tag_t;

    // A fully-associative slot also carries its own page size.
    typedef struct packed {
        tag_t            tag;
        logic [PS_W-1:0] ps;
    } slot_t;

    // One lookup request.
    typedef struct packed {
        logic [VA_W-1:0]   va;
        logic [ASID_W-1:0] asid;
        logic [PS_W-1:0]   gps;
    } query_t;

    // How many low tag bits lie inside the page pair for a given page size.
    function automatic logic [PS_W-1:0] cmp_shift(input logic [PS_W-1:0] ps);
        logic [PS_W-1:0] sh;
        if (ps > PS_W'(PS_FLOOR)) sh = ps - PS_W'(PS_FLOOR);
        else                      sh = '0;
        return sh;
    endfunction

    // Identifier / global test.
    function automatic logic space_ok(input tag_t t, input logic [ASID_W-1:0] cur);
        return t.glob || (t.asid == cur);
    endfunction

    // Page-pair compare: stored tag against query address at page size ps.
    function automatic logic pair_eq(input tag_t t, input logic [VA_W-1:0] va,
                                     input logic [PS_W-1:0] ps);
        logic [PS_W-1:0]   sh;
        logic [VPPN_W-1:0] qv;
        sh = cmp_shift(ps);
        qv = va[VA_W-1:TAG_LSB];
        return (t.vppn >> sh) == (qv >> sh);
    endfunction

endpackage

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins: scan from the top so the lowest index is kept.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    assign any = |hits;

endmodule

// File: rtl/tlb_sa_region.sv
module tlb_sa_region
    import tlb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  query_t                 q,
    input  logic                   wr_en,
    input  logic [WAY_W-1:0]       wr_way,
    input  logic [SET_W-1:0]       wr_set,
    input  tag_t                   wr_tag,
    input  logic                   wr_exist,
    output logic                   hit,
    output logic [WAY_W+SET_W-1:0] hit_idx
);
    logic [SET_W-1:0] set;
    logic [WAYS-1:0]  way_hit;
    logic [WAY_W-1:0] way_sel;

    // Set index: low bits of the page-pair number at the global page size.
    assign set = SET_W'(q.va >> ({1'b0, q.gps} + 7'd1));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_t            mem [SETS];
        logic [SETS-1:0] live;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(w))) mem[wr_set] <= wr_tag;
        end

        always_ff @(posedge clk) begin
            if (rst)                                  live <= '0;
            else if (wr_en && (wr_way == WAY_W'(w)))  live[wr_set] <= wr_exist;
        end

        assign way_hit[w] = live[set]
                          && space_ok(mem[set], q.asid)
                          && pair_eq(mem[set], q.va, q.gps);
    end

    tlb_first_hit #(.N(WAYS)) u_pick (
        .hits (way_hit),
        .any  (hit),
        .idx  (way_sel)
    );

    // Flat index within the region is way*SETS + set.
    assign hit_idx = {way_sel, set};

endmodule

// File: rtl/tlb_fa_region.sv
module tlb_fa_region
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  query_t        q,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_slot,
    input  slot_t         wr_data,
    input  logic          wr_exist,
    output logic          hit,
    output logic [IW-1:0] hit_slot
);
    logic [N-1:0] slot_hit;

    for (genvar k = 0; k < N; k++) begin : g_slot
        slot_t ent;
        logic  live;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == IW'(k))) ent <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)                               live <= 1'b0;
            else if (wr_en && (wr_slot == IW'(k))) live <= wr_exist;
        end

        // Each slot compares at its own page size.
        assign slot_hit[k] = live
                           && space_ok(ent.tag, q.asid)
                           && pair_eq(ent.tag, q.va, ent.ps);
    end

    tlb_first_hit #(.N(N)) u_pick (
        .hits (slot_hit),
        .any  (hit),
        .idx  (hit_slot)
    );

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    parameter int FA_N = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int FA_IW = (FA_N > 1) ? $clog2(FA_N) : 1,
    localparam int SA_N  = WAYS * SETS,
    localparam int TOTAL = SA_N + FA_N,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PS_W-1:0]   lk_gps,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPPN_W-1:0] wr_vppn,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_exist,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx
);
    query_t                   q;
    tag_t                     wtag;
    slot_t                    wslot;
    logic                     wr_sa, wr_fa;
    logic [WAY_W-1:0]         wr_way;
    logic [SET_W-1:0]         wr_set;
    logic [FA_IW-1:0]         wr_slot;
    logic                     sa_hit, fa_hit;
    logic [WAY_W+SET_W-1:0]   sa_idx;
    logic [FA_IW-1:0]         fa_slot;
    logic [IDX_W-1:0]         pick_idx;

    assign q     = '{va: lk_va, asid: lk_asid, gps: lk_gps};
    assign wtag  = '{vppn: wr_vppn, asid: wr_asid, glob: wr_global};
    assign wslot = '{tag: wtag, ps: wr_ps};

    // Write decode: low flat indices go to the set-indexed region, the rest to the slots.
    assign wr_sa   = wr_en && (wr_idx < IDX_W'(SA_N));
    assign wr_fa   = wr_en && !(wr_idx < IDX_W'(SA_N)) && (wr_idx < IDX_W'(TOTAL));
    assign wr_set  = wr_idx[SET_W-1:0];
    assign wr_way  = WAY_W'(wr_idx >> SET_W);
    assign wr_slot = FA_IW'(wr_idx - IDX_W'(SA_N));

    tlb_sa_region #(.WAYS(WAYS), .SETS(SETS)) u_sa (
        .clk      (clk),
        .rst      (rst),
        .q        (q),
        .wr_en    (wr_sa),
        .wr_way   (wr_way),
        .wr_set   (wr_set),
        .wr_tag   (wtag),
        .wr_exist (wr_exist),
        .hit      (sa_hit),
        .hit_idx  (sa_idx)
    );

    tlb_fa_region #(.N(FA_N)) u_fa (
        .clk      (clk),
        .rst      (rst),
        .q        (q),
        .wr_en    (wr_fa),
        .wr_slot  (wr_slot),
        .wr_data  (wslot),
        .wr_exist (wr_exist),
        .hit      (fa_hit),
        .hit_slot (fa_slot)
    );

    // The set-indexed region has priority over the slots.
    always_comb begin
        if (sa_hit)      pick_idx = IDX_W'(sa_idx);
        else if (fa_hit) pick_idx = IDX_W'(SA_N) + IDX_W'(fa_slot);
        else             pick_idx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (sa_hit || fa_hit);
            rsp_idx   <= lk_valid ? pick_idx : '0;
        end
    end

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
    parameter int IDX_W = 12,
    parameter int TOTAL = 2056
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             wr_en,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx
);
    logic any_write;

    always_ff @(posedge clk) begin
        if (rst)        any_write <= 1'b0;
        else if (wr_en) any_write <= 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !rsp_hit));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    assert_idle_no_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    assert_empty_table_misses_R5: assert property (@(posedge clk) disable iff (rst)
        !any_write |-> !rsp_hit);

    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_idx < IDX_W'(TOTAL)));

    assert_miss_idx_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0));

endmodule

bind tlb_lookup tlb_lookup_chk #(.IDX_W(IDX_W), .TOTAL(TOTAL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .wr_en     (wr_en),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx)
);

// File: tb/tlb_lookup_tb.sv
module tlb_lookup_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_va = '0;
    logic [9:0]  lk_asid = '0;
    logic [5:0]  lk_gps = 6'd13;
    logic        wr_en = 1'b0;
    logic [11:0] wr_idx = '0;
    logic [34:0] wr_vppn = '0;
    logic [5:0]  wr_ps = '0;
    logic [9:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic        wr_exist = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [11:0] rsp_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tlb_lookup u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_gps(lk_gps), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vppn(wr_vppn),
        .wr_ps(wr_ps), .wr_asid(wr_asid), .wr_global(wr_global), .wr_exist(wr_exist),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    localparam logic [47:0] VA_A = 48'h7A51_2345_6000;
    localparam logic [47:0] VA_G = 48'h0BCD_0042_8000;
    localparam logic [47:0] VA_E = 48'h3333_1111_4000;
    localparam logic [47:0] VA_B = 48'h4567_0020_0000;
    localparam logic [47:0] VA_C = 48'h1111_2222_8000;
    localparam logic [47:0] VA_D = 48'h2468_ACE0_C000;
    localparam logic [47:0] VA_H = 48'h5555_0001_2000;
    localparam logic [47:0] VA_S = 48'h6060_0606_0000;

    // Flat index of way w for address va at page size gps (R3).
    function automatic int sa_idx(input int w, input logic [47:0] va, input int gps);
        logic [47:0] pair;
        pair = va >> (gps + 1);
        return w * 256 + int'(pair[7:0]);
    endfunction

    task automatic judge(input string req, input logic v, input logic h, input int idx,
                         input logic ev, input logic eh, input int eidx);
        checks++;
        if (v !== ev || h !== eh || idx != eidx) begin
            errors++;
            $display("FAIL %s: valid/hit/idx got %0b/%0b/%0d expected %0b/%0b/%0d",
                     req, v, h, idx, ev, eh, eidx);
        end
    endtask

    task automatic put(input int idx, input logic [47:0] va, input int ps,
                       input int asid, input logic g, input logic ex);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'(idx); wr_vppn = va[47:13]; wr_ps = 6'(ps);
        wr_asid = 10'(asid); wr_global = g; wr_exist = ex;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [47:0] va, input int asid,
                        input int gps, input logic eh, input int eidx);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = 10'(asid); lk_gps = 6'(gps);
        @(negedge clk);
        lk_valid = 1'b0;
        judge(req, rsp_valid, rsp_hit, int'(rsp_idx), 1'b1, eh, eh ? eidx : 0);
    endtask

    // Write and lookup on the same edge (R10).
    task automatic collide(input string req, input int idx, input logic [47:0] va,
                           input logic ex, input logic eh, input int eidx);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'(idx); wr_vppn = va[47:13]; wr_ps = 6'd13;
        wr_asid = 10'd5; wr_global = 1'b0; wr_exist = ex;
        lk_valid = 1'b1; lk_va = va; lk_asid = 10'd5; lk_gps = 6'd13;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        judge(req, rsp_valid, rsp_hit, int'(rsp_idx), 1'b1, eh, eh ? eidx : 0);
    endtask

    task automatic t_reset;
        judge("R1 reset state", rsp_valid, rsp_hit, int'(rsp_idx), 1'b0, 1'b0, 0);
        look("R1 empty table", VA_A, 5, 13, 1'b0, 0);
        look("R11 miss index zero", VA_B, 0, 21, 1'b0, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        judge("R2 no request no response", rsp_valid, rsp_hit, int'(rsp_idx), 1'b0, 1'b0, 0);
    endtask

    task automatic t_set_region;
        put(sa_idx(3, VA_A, 13), VA_A, 0, 5, 1'b0, 1'b1);
        look("R3 way/set index", VA_A, 5, 13, 1'b1, sa_idx(3, VA_A, 13));
        look("R4 low bits ignored", VA_A ^ 48'h3FFF, 5, 13, 1'b1, sa_idx(3, VA_A, 13));
        look("R4 high bit differs", VA_A ^ (48'h1 << 30), 5, 13, 1'b0, 0);
        put(sa_idx(0, VA_H, 12), VA_H, 0, 5, 1'b0, 1'b1);
        look("R3 smaller global page", VA_H, 5, 12, 1'b1, sa_idx(0, VA_H, 12));
    endtask

    task automatic t_space;
        look("R6 other identifier", VA_A, 6, 13, 1'b0, 0);
        put(sa_idx(1, VA_G, 13), VA_G, 0, 9, 1'b1, 1'b1);
        look("R6 global any identifier", VA_G, 2, 13, 1'b1, sa_idx(1, VA_G, 13));
    endtask

    task automatic t_exist;
        put(sa_idx(5, VA_E, 13), VA_E, 0, 5, 1'b0, 1'b0);
        look("R5 absent entry", VA_E, 5, 13, 1'b0, 0);
    endtask

    task automatic t_slots;
        put(2048 + 2, VA_B, 21, 7, 1'b0, 1'b1);
        look("R7 slot own size", VA_B, 7, 13, 1'b1, 2050);
        look("R7 inside large pair", VA_B ^ (48'h1 << 21), 7, 13, 1'b1, 2050);
        look("R7 outside large pair", VA_B ^ (48'h1 << 22), 7, 13, 1'b0, 0);
    endtask

    task automatic t_order;
        put(2048 + 5, VA_C, 13, 5, 1'b0, 1'b1);
        put(2048 + 3, VA_C, 13, 5, 1'b0, 1'b1);
        look("R9 lowest slot", VA_C, 5, 13, 1'b1, 2051);
        put(sa_idx(6, VA_S, 13), VA_S, 0, 5, 1'b0, 1'b1);
        put(sa_idx(2, VA_S, 13), VA_S, 0, 5, 1'b0, 1'b1);
        look("R9 lowest way", VA_S, 5, 13, 1'b1, sa_idx(2, VA_S, 13));
        put(2048, VA_A, 13, 5, 1'b0, 1'b1);
        look("R8 set region first", VA_A, 5, 13, 1'b1, sa_idx(3, VA_A, 13));
        put(sa_idx(3, VA_A, 13), VA_A, 0, 5, 1'b0, 1'b0);
        look("R5 cleared, R8 slot falls through", VA_A, 5, 13, 1'b1, 2048);
    endtask

    task automatic t_same_cycle;
        collide("R10 fill seen next cycle", sa_idx(4, VA_D, 13), VA_D, 1'b1, 1'b0, 0);
        look("R10 fill visible", VA_D, 5, 13, 1'b1, sa_idx(4, VA_D, 13));
        collide("R10 clear sees old entry", sa_idx(4, VA_D, 13), VA_D, 1'b0,
                1'b1, sa_idx(4, VA_D, 13));
        look("R10 clear visible", VA_D, 5, 13, 1'b0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_set_region();
        t_space();
        t_exist();
        t_slots();
        t_order();
        t_same_cycle();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule